// File: doc/BRIEF.md
# Per-String LED Fault Latch

This block supervises a bank of LED current-sink channels. Each channel supplies two comparator results: a short flag, raised when the sink pin sits above the short trip level, and an open flag, raised when the pin is pulled close to ground because its string no longer conducts. When a flag holds steady long enough to pass its glitch filter, the channel's fault latch sets. The latch then forces that channel's sink enable low. All other channels keep running. A single active-low fault flag reports whether any channel has latched, and a status vector shows which channels have.

Open detection is only meaningful while the channel's PWM gate is conducting and the pin has had time to settle. The open flag is therefore ignored while the gate is off and for a blanking window after the gate turns on. A strap input disables short detection. Latched faults clear only through a clearing event: the power-up reset, undervoltage lockout, or the enable input being taken low. All comparator, gate, strap and clearing inputs are expected to be synchronous to the clock.

Top module: `led_fault_latch`

## Requirements
- R1: A short flag on channel i (masked by the strap) that is sampled high on FLT_CYC consecutive clock edges (default 16) sets the latch of channel i after the last of those edges.
- R2: An open flag on channel i counts only on edges where gate_i[i] is high and gate_i[i] was already high on the previous BLANK_CYC edges (default 64). FLT_CYC such consecutive edges set the latch of channel i. The open flag has no effect while the gate is low.
- R3: fault_no is 0 exactly when at least one channel is latched, and 1 otherwise.
- R4: While en_i is 1 and uvlo_i is 0, sink_en_o[i] is 1 for every channel that is not latched, whatever the state of the other channels. A latched channel has sink_en_o[i] = 0.
- R5: Latches, filters and blanking timers clear on rst_ni low, and on any edge where uvlo_i is 1 or en_i is 0. A clear takes priority over a fault that qualifies on the same edge. All sink enables are 0 while uvlo_i is 1 or en_i is 0.
- R6: While short_dis_i is 1, short flags are ignored and no short fault can latch.
- R7: A flag that drops for even one edge restarts its filter count from zero, so bursts shorter than FLT_CYC edges never latch.
- R8: fault_stat_o bit i is 1 exactly when channel i is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| uvlo_i | input | 1 | Undervoltage lockout, clears while high |
| en_i | input | 1 | Chip enable, clears while low |
| short_dis_i | input | 1 | Strap that disables short detection |
| gate_i | input | N_CH | Per-channel PWM gate, high = conducting |
| short_cmp_i | input | N_CH | Per-channel short comparator result |
| open_cmp_i | input | N_CH | Per-channel open comparator result |
| sink_en_o | output | N_CH | Per-channel current-sink enable |
| fault_stat_o | output | N_CH | Per-channel latched fault status |
| fault_no | output | 1 | Shared fault flag, active low |

## Verification
Two events can collide: a filter reaching its qualifying edge, and a clearing event arriving on that same edge. The bench holds a short flag for one edge less than the filter length. On the next edge it raises uvlo_i while the flag stays high. It then expects no latch, followed by a full, fresh FLT_CYC-edge count once lockout is released. A short and an open qualifying together on one channel, and all channels tripping at once, are also driven. Every cycle is compared against a behavioural per-channel run-length model.

// File: rtl/lfl_pkg.sv
package lfl_pkg;
  localparam int unsigned DEF_N_CH      = 8;
  localparam int unsigned DEF_FLT_CYC   = 16;
  localparam int unsigned DEF_BLANK_CYC = 64;

  function automatic int unsigned cnt_w(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/lfl_filt.sv
// Consecutive-edge qualifier: hit_o when in_i is high on the CNT-th edge in a row
module lfl_filt #(
  parameter int unsigned CNT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic in_i,
  output logic hit_o
);
  localparam int unsigned CW  = lfl_pkg::cnt_w(CNT);
  localparam logic [CW-1:0] TOP = CW'(CNT - 1);

  logic [CW-1:0] cnt_q;

  assign hit_o = in_i & (cnt_q == TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (!in_i)       cnt_q <= '0;
    else if (cnt_q != TOP) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/lfl_blank.sv
// Gate-on blanking: ok_o once gate has been high for CYC prior edges
module lfl_blank #(
  parameter int unsigned CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic gate_i,
  output logic ok_o
);
  localparam int unsigned CW  = lfl_pkg::cnt_w(CYC);
  localparam logic [CW-1:0] TOP = CW'(CYC);

  logic [CW-1:0] cnt_q;

  assign ok_o = gate_i & (cnt_q == TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (clr_i)        cnt_q <= '0;
    else if (!gate_i)      cnt_q <= '0;
    else if (cnt_q != TOP) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/lfl_chan.sv
module lfl_chan #(
  parameter int unsigned FLT_CYC   = 16,
  parameter int unsigned BLANK_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic short_dis_i,
  input  logic gate_i,
  input  logic short_i,
  input  logic open_i,
  output logic lat_o
);
  logic blank_ok, short_hit, open_hit, lat_q;

  lfl_blank #(.CYC(BLANK_CYC)) u_blank (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
    .gate_i(gate_i), .ok_o(blank_ok)
  );

  lfl_filt #(.CNT(FLT_CYC)) u_short (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
    .in_i(short_i & ~short_dis_i), .hit_o(short_hit)
  );

  lfl_filt #(.CNT(FLT_CYC)) u_open (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
    .in_i(open_i & blank_ok), .hit_o(open_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    lat_q <= 1'b0;
    else if (clr_i)                 lat_q <= 1'b0;  // clear wins
    else if (short_hit || open_hit) lat_q <= 1'b1;
  end

  assign lat_o = lat_q;
endmodule

// File: rtl/led_fault_latch.sv
module led_fault_latch #(
  parameter int unsigned N_CH      = lfl_pkg::DEF_N_CH,
  parameter int unsigned FLT_CYC   = lfl_pkg::DEF_FLT_CYC,
  parameter int unsigned BLANK_CYC = lfl_pkg::DEF_BLANK_CYC
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            uvlo_i,
  input  logic            en_i,
  input  logic            short_dis_i,
  input  logic [N_CH-1:0] gate_i,
  input  logic [N_CH-1:0] short_cmp_i,
  input  logic [N_CH-1:0] open_cmp_i,
  output logic [N_CH-1:0] sink_en_o,
  output logic [N_CH-1:0] fault_stat_o,
  output logic            fault_no
);
  logic            clr;
  logic            run_ok;
  logic [N_CH-1:0] lat;

  assign clr    = uvlo_i | ~en_i;
  assign run_ok = en_i & ~uvlo_i;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    lfl_chan #(.FLT_CYC(FLT_CYC), .BLANK_CYC(BLANK_CYC)) u_chan (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr),
      .short_dis_i(short_dis_i), .gate_i(gate_i[g]),
      .short_i(short_cmp_i[g]), .open_i(open_cmp_i[g]),
      .lat_o(lat[g])
    );
  end

  assign fault_stat_o = lat;
  assign sink_en_o    = ~lat & {N_CH{run_ok}};
  assign fault_no     = ~|lat;
endmodule

// File: rtl/lfl_checker.sv
module lfl_checker #(
  parameter int unsigned N_CH = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            uvlo_i,
  input logic            en_i,
  input logic            short_dis_i,
  input logic [N_CH-1:0] gate_i,
  input logic [N_CH-1:0] short_cmp_i,
  input logic [N_CH-1:0] open_cmp_i,
  input logic [N_CH-1:0] sink_en_o,
  input logic [N_CH-1:0] fault_stat_o,
  input logic            fault_no
);
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uvlo_i || !en_i) |=> (fault_stat_o == '0));

  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !uvlo_i) |=> ((fault_stat_o & $past(fault_stat_o)) == $past(fault_stat_o)));

  p_cause_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((fault_stat_o & ~$past(fault_stat_o)
               & ~$past(short_cmp_i) & ~$past(open_cmp_i & gate_i)) == '0));

  p_strap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_dis_i |=> ((fault_stat_o & ~$past(fault_stat_o)
                      & ~$past(open_cmp_i & gate_i)) == '0));

  p_gate_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (short_cmp_i == '0) |=> ((fault_stat_o & ~$past(fault_stat_o) & ~$past(gate_i)) == '0));

  p_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_no == (fault_stat_o == '0));

  p_healthy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !uvlo_i) |-> (sink_en_o == ~fault_stat_o));

  p_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uvlo_i || !en_i) |-> (sink_en_o == '0));
endmodule

bind led_fault_latch lfl_checker #(.N_CH(N_CH)) u_lfl_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .uvlo_i(uvlo_i), .en_i(en_i),
  .short_dis_i(short_dis_i), .gate_i(gate_i), .short_cmp_i(short_cmp_i),
  .open_cmp_i(open_cmp_i), .sink_en_o(sink_en_o),
  .fault_stat_o(fault_stat_o), .fault_no(fault_no)
);

// File: tb/led_fault_latch_bench.sv
module led_fault_latch_bench;
  localparam int N  = 8;
  localparam int F  = 16;
  localparam int BL = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uvlo = 1'b0, en = 1'b0, sdis = 1'b0;
  logic [N-1:0] gate = '0, shrt = '0, opn = '0;
  logic [N-1:0] sink_en, stat;
  logic fault_n;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  int sc_run[N], op_run[N], g_run[N];
  bit m_lat[N];

  always #5 clk = ~clk;

  led_fault_latch u_led_fault_latch (
    .clk_i(clk), .rst_ni(rst_n), .uvlo_i(uvlo), .en_i(en),
    .short_dis_i(sdis), .gate_i(gate), .short_cmp_i(shrt),
    .open_cmp_i(opn), .sink_en_o(sink_en), .fault_stat_o(stat),
    .fault_no(fault_n)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, updated on each edge from inputs stable since the negedge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        sc_run[i] = 0; op_run[i] = 0; g_run[i] = 0; m_lat[i] = 0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (uvlo || !en) begin
          sc_run[i] = 0; op_run[i] = 0; g_run[i] = 0; m_lat[i] = 0;
        end else begin
          bit s, o;
          s = shrt[i] && !sdis;
          o = opn[i] && gate[i] && (g_run[i] >= BL);
          if ((s && sc_run[i] >= F-1) || (o && op_run[i] >= F-1)) m_lat[i] = 1;
          sc_run[i] = s ? ((sc_run[i] + 1 > F-1) ? F-1 : sc_run[i] + 1) : 0;
          op_run[i] = o ? ((op_run[i] + 1 > F-1) ? F-1 : op_run[i] + 1) : 0;
          g_run[i]  = gate[i] ? ((g_run[i] + 1 > BL) ? BL : g_run[i] + 1) : 0;
        end
      end
    end
  end

  // per-cycle comparison at the negedge
  always @(negedge clk) begin
    logic [N-1:0] ml, me;
    cyc++;
    for (int i = 0; i < N; i++) ml[i] = m_lat[i];
    me = (en && !uvlo) ? ~ml : '0;
    if (rst_n) begin
      chk("R8 status", stat, ml);
      chk("R4 sink_en", sink_en, me);
      chk("R3 fault_no", {{(N-1){1'b0}}, fault_n}, {{(N-1){1'b0}}, (ml == '0)});
    end
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_n(3);
    chk("R5 reset status", stat, '0);
    chk("R3 reset flag", {{(N-1){1'b0}}, fault_n}, {{(N-1){1'b0}}, 1'b1});
    rst_n = 1'b1;
    wait_n(2);
    chk("R5 sinks off while disabled", sink_en, '0);
    en = 1'b1;
    wait_n(2);
    chk("R4 all sinks on", sink_en, 8'hFF);

    // R7: short burst one edge too short, then a break
    shrt[0] = 1'b1; wait_n(F-1); shrt[0] = 1'b0; wait_n(1);
    shrt[0] = 1'b1; wait_n(F-1);
    chk("R7 burst rejected", stat, '0);
    // R1: one more edge completes a fresh run? no, run was restarted: finish it
    wait_n(1);
    chk("R1 short latched", stat, 8'h01);
    chk("R4 other strings run", sink_en, 8'hFE);
    shrt[0] = 1'b0; wait_n(5);
    chk("R1 latch holds", stat, 8'h01);

    // R2: open with gate off ignored
    opn[1] = 1'b1; wait_n(100);
    chk("R2 gate off ignored", stat, 8'h01);
    gate[1] = 1'b1; wait_n(BL + F - 1);
    chk("R2 blanking holds off", stat, 8'h01);
    wait_n(1);
    chk("R2 open latched", stat, 8'h03);
    opn[1] = 1'b0; gate[1] = 1'b0;

    // R5: enable cycling clears
    en = 1'b0; wait_n(1);
    chk("R5 enable clears", stat, '0);
    en = 1'b1; wait_n(2);

    // R6: strap disables short detection
    sdis = 1'b1; shrt[2] = 1'b1; wait_n(40);
    chk("R6 strap blocks short", stat, '0);
    sdis = 1'b0; wait_n(F);
    chk("R6 short after strap release", stat, 8'h04);
    shrt[2] = 1'b0;
    uvlo = 1'b1; wait_n(1);
    chk("R5 uvlo clears", stat, '0);
    chk("R5 sinks off in uvlo", sink_en, '0);
    uvlo = 1'b0; wait_n(2);

    // R5 collision: clear on the qualifying edge
    shrt[3] = 1'b1; wait_n(F-1);
    uvlo = 1'b1; wait_n(1);
    uvlo = 1'b0;
    chk("R5 clear wins over trip", stat, '0);
    wait_n(F-1);
    chk("R5 count restarted", stat, '0);
    wait_n(1);
    chk("R1 latched after restart", stat, 8'h08);
    shrt[3] = 1'b0;

    // short and open together on one channel, then every channel
    en = 1'b0; wait_n(1); en = 1'b1;
    gate = '1; wait_n(BL);
    shrt[5] = 1'b1; opn[5] = 1'b1; wait_n(F);
    chk("R1 R2 joint trip", stat, 8'h20);
    shrt = '1; wait_n(F);
    chk("R8 all latched", stat, 8'hFF);
    chk("R3 flag low", {{(N-1){1'b0}}, fault_n}, '0);
    chk("R4 all sinks off", sink_en, '0);
    shrt = '0; opn = '0; gate = '0;
    wait_n(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule